// File: doc/BRIEF.md
# PIO Timing Count Calculator

This block turns a requested programmed-I/O transfer mode and a target cycle time into the clock counts that an ATA-style timing generator needs. The caller supplies the mode, the cycle time in nanoseconds, the period of the bus clock in nanoseconds, a chip revision value and, for a drive that shares its timing registers with a companion drive on the same channel, the companion's stored counts and a present flag. An internal table gives the address setup time and the strobe active time for each mode. From these the block derives the setup, active and recovery counts with rounding up, minimum and maximum clamps and a revision adjustment.

One iterative divider is shared by four ceiling divisions (setup time, active time, recovery time and full cycle time). When every quotient is ready, the counts are shaped, merged with the companion drive if the channel is shared, and encoded. The block then presents the drive's own counts, which the caller stores for later merges, together with an encoded setup byte and a packed active/recovery byte that go straight into the timing registers.

Top module: `pio_timing_calc`

## Requirements
- R1: A requested mode above 5 uses the mode-5 table entry. Table (setup ns / active ns): mode 0 70/165, mode 1 50/125, mode 2 30/100, mode 3 30/80, mode 4 25/70, mode 5 20/50.
- R2: Setup, active, recovery and cycle counts are each the matching time divided by the clock period, rounded up. Recovery time is the cycle time minus setup time minus active time, or zero when that difference would be negative. A clock period of 0 is treated as 1.
- R3: The active count is at least 2.
- R4: The recovery count is the larger of its own rounded-up count and the cycle count minus the setup and active counts (zero if negative). It is then raised to at least 2.
- R5: If recovery exceeds 17, the excess is added to the active count and recovery becomes 17. After that, active is limited to 16.
- R6: For a revision value above 1, recovery is reduced by one. For any revision, recovery is then limited to 16.
- R7: When shared_channel and mate_present are both high, each of setup, active and recovery written to setup_field and drw_byte is the larger of the own value and the mate value. Otherwise the mate inputs have no effect. own_setup, own_active and own_recovery always carry the unmerged values.
- R8: own_setup is the setup count limited to 5. setup_field encodes the (merged) setup count as follows: 1 or 2 give 0x40, 3 gives 0x80, 4 gives 0x00, and any other value gives 0xC0.
- R9: drw_byte holds the active count in bits 7:4 and the recovery count in bits 3:0. A count of 16 is written as nibble 0.
- R10: A start pulse while busy is low launches a calculation. busy is high from the next cycle until the cycle in which valid pulses for exactly one cycle, and busy is low in that cycle. The outputs change only in a valid cycle.
- R11: A start pulse while busy is high is ignored. Inputs that change during a calculation do not affect its result.
- R12: After reset, busy, valid and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a calculation |
| pio_mode | input | MODE_W (3) | Requested transfer mode |
| cycle_ns | input | TIME_W (11) | Requested cycle time, ns |
| clk_period_ns | input | PER_W (8) | Bus clock period, ns |
| chip_rev | input | REV_W (2) | Revision value |
| shared_channel | input | 1 | Drive shares its register set with a companion |
| mate_present | input | 1 | Companion drive exists |
| mate_setup | input | CNT_W (5) | Companion setup count |
| mate_active | input | CNT_W (5) | Companion active count |
| mate_recovery | input | CNT_W (5) | Companion recovery count |
| busy | output | 1 | Calculation in progress |
| valid | output | 1 | One-cycle result strobe |
| own_setup | output | CNT_W (5) | Unmerged setup count |
| own_active | output | CNT_W (5) | Unmerged active count |
| own_recovery | output | CNT_W (5) | Unmerged recovery count |
| setup_field | output | 8 | Encoded setup value |
| drw_byte | output | 8 | Packed active/recovery byte |

## Verification
The result strobe and the acceptance of a new request can fall in the same cycle, because busy drops in the same cycle that valid pulses. The bench raises start exactly in the valid cycle. It then checks that busy rises in the next cycle while the previous result is still held on the outputs, and that the following strobe carries the second request's counts. A start raised in the middle of a calculation, with different operands, must leave the first result unchanged.

// File: rtl/pio_calc_pkg.sv
package pio_calc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_WRAP = 2'd2
  } calc_state_e;

  // Address setup time per mode, ns (modes above 5 use the fastest entry)
  function automatic logic [7:0] mode_setup_ns(input int unsigned m);
    case (m)
      0:       return 8'd70;
      1:       return 8'd50;
      2:       return 8'd30;
      3:       return 8'd30;
      4:       return 8'd25;
      default: return 8'd20;
    endcase
  endfunction

  // Strobe active time per mode, ns
  function automatic logic [7:0] mode_active_ns(input int unsigned m);
    case (m)
      0:       return 8'd165;
      1:       return 8'd125;
      2:       return 8'd100;
      3:       return 8'd80;
      4:       return 8'd70;
      default: return 8'd50;
    endcase
  endfunction

  // Setup count to register field
  function automatic logic [7:0] enc_setup(input int unsigned c);
    case (c)
      1, 2:    return 8'h40;
      3:       return 8'h80;
      4:       return 8'h00;
      default: return 8'hC0;
    endcase
  endfunction

endpackage

// File: rtl/pio_ceil_div.sv
module pio_ceil_div #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] ceil_q
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_r, quo_r, den_r;
  logic [CW-1:0] cnt_r;
  logic          run_r;
  logic [W:0]    trial;

  assign trial  = {rem_r, quo_r[W-1]};
  assign ceil_q = quo_r + W'(rem_r != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_r <= '0;
      quo_r <= '0;
      den_r <= W'(1);
      cnt_r <= '0;
      run_r <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        rem_r <= '0;
        quo_r <= dividend;
        den_r <= (divisor == '0) ? W'(1) : divisor;
        cnt_r <= CW'(W);
        run_r <= 1'b1;
      end else if (run_r) begin
        if (trial >= {1'b0, den_r}) begin
          rem_r <= W'(trial - {1'b0, den_r});
          quo_r <= {quo_r[W-2:0], 1'b1};
        end else begin
          rem_r <= trial[W-1:0];
          quo_r <= {quo_r[W-2:0], 1'b0};
        end
        cnt_r <= cnt_r - CW'(1);
        if (cnt_r == CW'(1)) begin
          run_r <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pio_count_shaper.sv
module pio_count_shaper #(
  parameter int TIME_W = 11,
  parameter int CNT_W  = 5,
  parameter int REV_W  = 2
) (
  input  logic [TIME_W-1:0] q_setup,
  input  logic [TIME_W-1:0] q_active,
  input  logic [TIME_W-1:0] q_recov,
  input  logic [TIME_W-1:0] q_cycle,
  input  logic [REV_W-1:0]  rev,
  output logic [CNT_W-1:0]  s_cnt,
  output logic [CNT_W-1:0]  a_cnt,
  output logic [CNT_W-1:0]  r_cnt
);
  localparam int XW = TIME_W + 2;
  localparam logic [XW-1:0] K1  = XW'(1);
  localparam logic [XW-1:0] K2  = XW'(2);
  localparam logic [XW-1:0] K5  = XW'(5);
  localparam logic [XW-1:0] K16 = XW'(16);
  localparam logic [XW-1:0] K17 = XW'(17);

  logic [XW-1:0] qs, qa, qr, qc, a1, sa, r2, r1, a2, a3, r3, r4, s1;

  always_comb begin
    qs = XW'(q_setup);
    qa = XW'(q_active);
    qr = XW'(q_recov);
    qc = XW'(q_cycle);
    a1 = (qa < K2) ? K2 : qa;
    sa = qs + a1;
    r2 = (qc > sa) ? (qc - sa) : '0;
    r1 = (qr > r2) ? qr : r2;
    if (r1 < K2) r1 = K2;
    if (r1 > K17) begin
      a2 = a1 + (r1 - K17);
      r1 = K17;
    end else begin
      a2 = a1;
    end
    a3 = (a2 > K16) ? K16 : a2;
    r3 = (rev > REV_W'(1)) ? (r1 - K1) : r1;
    r4 = (r3 > K16) ? K16 : r3;
    s1 = (qs > K5) ? K5 : qs;
    s_cnt = CNT_W'(s1);
    a_cnt = CNT_W'(a3);
    r_cnt = CNT_W'(r4);
  end
endmodule

// File: rtl/pio_channel_merge.sv
module pio_channel_merge #(
  parameter int CNT_W = 5
) (
  input  logic             merge_en,
  input  logic [CNT_W-1:0] own_s,
  input  logic [CNT_W-1:0] own_a,
  input  logic [CNT_W-1:0] own_r,
  input  logic [CNT_W-1:0] mate_s,
  input  logic [CNT_W-1:0] mate_a,
  input  logic [CNT_W-1:0] mate_r,
  output logic [7:0]       setup_field,
  output logic [7:0]       drw_byte
);
  import pio_calc_pkg::*;

  logic [CNT_W-1:0] own_v [3];
  logic [CNT_W-1:0] mate_v [3];
  logic [CNT_W-1:0] pick [3];

  assign own_v[0]  = own_s;
  assign own_v[1]  = own_a;
  assign own_v[2]  = own_r;
  assign mate_v[0] = mate_s;
  assign mate_v[1] = mate_a;
  assign mate_v[2] = mate_r;

  for (genvar g = 0; g < 3; g++) begin : g_slow
    assign pick[g] = (merge_en && (mate_v[g] > own_v[g])) ? mate_v[g] : own_v[g];
  end

  assign setup_field = enc_setup(int'(pick[0]));
  assign drw_byte    = {pick[1][3:0], pick[2][3:0]};
endmodule

// File: rtl/pio_timing_calc.sv
module pio_timing_calc #(
  parameter int MODE_W = 3,
  parameter int TIME_W = 11,
  parameter int PER_W  = 8,
  parameter int REV_W  = 2,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [MODE_W-1:0] pio_mode,
  input  logic [TIME_W-1:0] cycle_ns,
  input  logic [PER_W-1:0]  clk_period_ns,
  input  logic [REV_W-1:0]  chip_rev,
  input  logic              shared_channel,
  input  logic              mate_present,
  input  logic [CNT_W-1:0]  mate_setup,
  input  logic [CNT_W-1:0]  mate_active,
  input  logic [CNT_W-1:0]  mate_recovery,
  output logic              busy,
  output logic              valid,
  output logic [CNT_W-1:0]  own_setup,
  output logic [CNT_W-1:0]  own_active,
  output logic [CNT_W-1:0]  own_recovery,
  output logic [7:0]        setup_field,
  output logic [7:0]        drw_byte
);
  import pio_calc_pkg::*;

  localparam int NDIV = 4;
  localparam int OPW  = $clog2(NDIV);

  calc_state_e       state;
  logic [OPW-1:0]    op;
  logic              div_go, div_done;
  logic [TIME_W-1:0] div_q, dvd;

  logic [MODE_W-1:0] l_mode;
  logic [TIME_W-1:0] l_cycle;
  logic [PER_W-1:0]  l_period;
  logic [REV_W-1:0]  l_rev;
  logic              l_merge;
  logic [CNT_W-1:0]  l_ms, l_ma, l_mr;
  logic [TIME_W-1:0] q_r [NDIV];

  logic [TIME_W-1:0] t_setup, t_active, t_rec;
  logic [TIME_W:0]   t_sum;
  logic [CNT_W-1:0]  c_s, c_a, c_r;
  logic [7:0]        m_sf, m_drw;

  // Operand preparation
  assign t_setup  = TIME_W'(mode_setup_ns(int'(l_mode)));
  assign t_active = TIME_W'(mode_active_ns(int'(l_mode)));
  assign t_sum    = {1'b0, t_setup} + {1'b0, t_active};
  assign t_rec    = ({1'b0, l_cycle} > t_sum) ? TIME_W'({1'b0, l_cycle} - t_sum) : '0;

  always_comb begin
    case (op)
      OPW'(0): dvd = t_setup;
      OPW'(1): dvd = t_active;
      OPW'(2): dvd = t_rec;
      default: dvd = l_cycle;
    endcase
  end

  pio_ceil_div #(.W(TIME_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .go       (div_go),
    .dividend (dvd),
    .divisor  (TIME_W'(l_period)),
    .done     (div_done),
    .ceil_q   (div_q)
  );

  pio_count_shaper #(.TIME_W(TIME_W), .CNT_W(CNT_W), .REV_W(REV_W)) u_shape (
    .q_setup  (q_r[0]),
    .q_active (q_r[1]),
    .q_recov  (q_r[2]),
    .q_cycle  (q_r[3]),
    .rev      (l_rev),
    .s_cnt    (c_s),
    .a_cnt    (c_a),
    .r_cnt    (c_r)
  );

  pio_channel_merge #(.CNT_W(CNT_W)) u_merge (
    .merge_en    (l_merge),
    .own_s       (c_s),
    .own_a       (c_a),
    .own_r       (c_r),
    .mate_s      (l_ms),
    .mate_a      (l_ma),
    .mate_r      (l_mr),
    .setup_field (m_sf),
    .drw_byte    (m_drw)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      op           <= '0;
      div_go       <= 1'b0;
      busy         <= 1'b0;
      valid        <= 1'b0;
      l_mode       <= '0;
      l_cycle      <= '0;
      l_period     <= '0;
      l_rev        <= '0;
      l_merge      <= 1'b0;
      l_ms         <= '0;
      l_ma         <= '0;
      l_mr         <= '0;
      own_setup    <= '0;
      own_active   <= '0;
      own_recovery <= '0;
      setup_field  <= '0;
      drw_byte     <= '0;
      for (int i = 0; i < NDIV; i++) q_r[i] <= '0;
    end else begin
      valid  <= 1'b0;
      div_go <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            l_mode   <= pio_mode;
            l_cycle  <= cycle_ns;
            l_period <= clk_period_ns;
            l_rev    <= chip_rev;
            l_merge  <= shared_channel && mate_present;
            l_ms     <= mate_setup;
            l_ma     <= mate_active;
            l_mr     <= mate_recovery;
            op       <= '0;
            div_go   <= 1'b1;
            busy     <= 1'b1;
            state    <= ST_DIV;
          end
        end
        ST_DIV: begin
          if (div_done) begin
            q_r[op] <= div_q;
            if (op == OPW'(NDIV - 1)) begin
              state <= ST_WRAP;
            end else begin
              op     <= op + OPW'(1);
              div_go <= 1'b1;
            end
          end
        end
        ST_WRAP: begin
          own_setup    <= c_s;
          own_active   <= c_a;
          own_recovery <= c_r;
          setup_field  <= m_sf;
          drw_byte     <= m_drw;
          valid        <= 1'b1;
          busy         <= 1'b0;
          state        <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pio_timing_calc_chk.sv
module pio_timing_calc_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             valid,
  input logic [CNT_W-1:0] own_setup,
  input logic [CNT_W-1:0] own_active,
  input logic [CNT_W-1:0] own_recovery,
  input logic [7:0]       setup_field,
  input logic [7:0]       drw_byte
);
  function automatic int unsigned nib_val(input logic [3:0] n);
    return (n == 4'd0) ? 16 : int'(n);
  endfunction

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid); // R10
  AST_VALID_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    valid |-> !busy); // R10
  AST_BUSY_ENDS_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> valid); // R10
  AST_START_LAUNCHES: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R10
  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> (busy || valid)); // R11
  AST_OUTPUTS_HELD: assert property (@(posedge clk) disable iff (rst)
    !valid |-> ($stable(setup_field) && $stable(drw_byte) && $stable(own_setup)
                && $stable(own_active) && $stable(own_recovery))); // R10
  AST_ACTIVE_RANGE: assert property (@(posedge clk) disable iff (rst)
    valid |-> (own_active >= 2 && own_active <= 16)); // R3
  AST_RECOV_RANGE: assert property (@(posedge clk) disable iff (rst)
    valid |-> (own_recovery >= 1 && own_recovery <= 16)); // R6
  AST_SETUP_RANGE: assert property (@(posedge clk) disable iff (rst)
    valid |-> (own_setup >= 1 && own_setup <= 5)); // R8
  AST_SETUP_CODE: assert property (@(posedge clk) disable iff (rst)
    valid |-> (setup_field[5:0] == 6'd0)); // R8
  AST_MERGE_NOT_FASTER: assert property (@(posedge clk) disable iff (rst)
    valid |-> (nib_val(drw_byte[7:4]) >= int'(own_active)
               && nib_val(drw_byte[3:0]) >= int'(own_recovery))); // R7
endmodule

bind pio_timing_calc pio_timing_calc_chk #(.CNT_W(CNT_W)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .busy         (busy),
  .valid        (valid),
  .own_setup    (own_setup),
  .own_active   (own_active),
  .own_recovery (own_recovery),
  .setup_field  (setup_field),
  .drw_byte     (drw_byte)
);

// File: tb/test_pio_timing_calc.sv
module test_pio_timing_calc;
  localparam int MODE_W = 3, TIME_W = 11, PER_W = 8, REV_W = 2, CNT_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [MODE_W-1:0] pio_mode = '0;
  logic [TIME_W-1:0] cycle_ns = '0;
  logic [PER_W-1:0]  clk_period_ns = '0;
  logic [REV_W-1:0]  chip_rev = '0;
  logic shared_channel = 1'b0, mate_present = 1'b0;
  logic [CNT_W-1:0] mate_setup = '0, mate_active = '0, mate_recovery = '0;
  logic busy, valid;
  logic [CNT_W-1:0] own_setup, own_active, own_recovery;
  logic [7:0] setup_field, drw_byte;

  int n_cmp = 0, n_bad = 0;
  bit hs_bad;

  always #10 clk = ~clk;

  pio_timing_calc #(.MODE_W(MODE_W), .TIME_W(TIME_W), .PER_W(PER_W),
                    .REV_W(REV_W), .CNT_W(CNT_W)) i_pio_timing_calc (
    .clk(clk), .rst(rst), .start(start), .pio_mode(pio_mode), .cycle_ns(cycle_ns),
    .clk_period_ns(clk_period_ns), .chip_rev(chip_rev), .shared_channel(shared_channel),
    .mate_present(mate_present), .mate_setup(mate_setup), .mate_active(mate_active),
    .mate_recovery(mate_recovery), .busy(busy), .valid(valid), .own_setup(own_setup),
    .own_active(own_active), .own_recovery(own_recovery), .setup_field(setup_field),
    .drw_byte(drw_byte)
  );

  function automatic int cdiv(input int x, input int p);
    int pp = (p == 0) ? 1 : p;
    return (x + pp - 1) / pp;
  endfunction

  // Reference: {own_s, own_a, own_r, setup_field, drw_byte}
  function automatic logic [30:0] model(input int m, input int cyc, input int per,
      input int rev, input bit sh, input bit mp, input int ms, input int ma, input int mr);
    int st, at, rt, qs, qa, qr, qc, a, r, r2, s, fs, fa, fr, sf;
    st = (m == 0) ? 70 : (m == 1) ? 50 : (m <= 3) ? 30 : (m == 4) ? 25 : 20;  // R1
    at = (m == 0) ? 165 : (m == 1) ? 125 : (m == 2) ? 100 : (m == 3) ? 80 : (m == 4) ? 70 : 50;
    rt = (cyc > st + at) ? cyc - st - at : 0;                                 // R2
    qs = cdiv(st, per); qa = cdiv(at, per); qr = cdiv(rt, per); qc = cdiv(cyc, per);
    a = (qa < 2) ? 2 : qa;                                                    // R3
    r2 = (qc > qs + a) ? qc - qs - a : 0;                                     // R4
    r = (qr > r2) ? qr : r2;
    if (r < 2) r = 2;
    if (r > 17) begin a = a + r - 17; r = 17; end                             // R5
    if (a > 16) a = 16;
    if (rev > 1) r = r - 1;                                                   // R6
    if (r > 16) r = 16;
    s = (qs > 5) ? 5 : qs;                                                    // R8
    fs = s; fa = a; fr = r;
    if (sh && mp) begin                                                       // R7
      if (ms > fs) fs = ms;
      if (ma > fa) fa = ma;
      if (mr > fr) fr = mr;
    end
    sf = (fs == 1 || fs == 2) ? 'h40 : (fs == 3) ? 'h80 : (fs == 4) ? 'h00 : 'hC0;
    return {5'(s), 5'(a), 5'(r), 8'(sf), 4'(fa % 16), 4'(fr % 16)};           // R9
  endfunction

  function automatic logic [30:0] got();
    return {own_setup, own_active, own_recovery, setup_field, drw_byte};
  endfunction

  task automatic check(input string req, input logic [30:0] act, input logic [30:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_in(input int m, input int cyc, input int per, input int rev,
      input bit sh, input bit mp, input int ms, input int ma, input int mr);
    pio_mode = MODE_W'(m); cycle_ns = TIME_W'(cyc); clk_period_ns = PER_W'(per);
    chip_rev = REV_W'(rev); shared_channel = sh; mate_present = mp;
    mate_setup = CNT_W'(ms); mate_active = CNT_W'(ma); mate_recovery = CNT_W'(mr);
  endtask

  // Called at a negedge; leaves at the next negedge
  task automatic launch();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    hs_bad = 0;
    while (!valid && n < 400) begin
      if (!busy) hs_bad = 1;
      @(negedge clk);
      n++;
    end
    if (!valid) hs_bad = 1;
  endtask

  task automatic run_chk(input string req, input int m, input int cyc, input int per,
      input int rev, input bit sh, input bit mp, input int ms, input int ma, input int mr);
    set_in(m, cyc, per, rev, sh, mp, ms, ma, mr);
    launch();
    wait_done();
    check("R10 handshake", {30'd0, hs_bad | busy}, 31'd0);
    check(req, got(), model(m, cyc, per, rev, sh, mp, ms, ma, mr));
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int pers[5] = '{0, 10, 20, 30, 33};
    int cycs[8] = '{0, 50, 120, 240, 383, 600, 900, 2000};
    int rvs[2]  = '{1, 3};
    int vs[3]   = '{1, 3, 5};
    int va[3]   = '{2, 9, 16};
    int vr[3]   = '{1, 8, 16};
    logic [30:0] first;
    repeat (4) @(negedge clk);
    // R12: reset state
    check("R12 reset", {got(), busy, valid}, 33'd0);
    rst = 1'b0;
    @(negedge clk);

    // R1..R6, R8, R9 sweep; mate inputs driven but merge off (R7 ignore)
    for (int m = 0; m < 8; m++)
      for (int c = 0; c < 8; c++)
        for (int p = 0; p < 5; p++)
          for (int v = 0; v < 2; v++)
            run_chk("R1-sweep R2 R3 R4 R5 R6 R8 R9", m, cycs[c], pers[p], rvs[v],
                    (c % 2) == 0, (c % 2) == 1, 5, 16, 16);

    // R7: merge sweep with and without companion present
    for (int mp = 0; mp < 2; mp++)
      for (int i = 0; i < 3; i++)
        for (int j = 0; j < 3; j++)
          for (int k = 0; k < 3; k++)
            for (int m = 0; m < 3; m++)
              for (int c = 0; c < 2; c++)
                run_chk("R7 merge", (m == 0) ? 0 : (m == 1) ? 4 : 5, (c == 0) ? 120 : 600,
                        30, 2, 1'b1, mp[0], vs[i], va[j], vr[k]);

    // R11: start during a calculation with other operands is ignored
    for (int t = 0; t < 4; t++) begin
      set_in(t, 383, 30, 2, 1'b0, 1'b0, 0, 0, 0);
      launch();
      repeat (3 + t * 7) @(negedge clk);
      set_in(5, 2000, 10, 0, 1'b1, 1'b1, 5, 16, 16);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      check("R11 ignored start", got(), model(t, 383, 30, 2, 1'b0, 1'b0, 0, 0, 0));
      @(negedge clk);
      check("R11 no second run", {30'd0, busy}, 31'd0);
    end

    // R10: start in the same cycle as the valid pulse
    for (int t = 0; t < 3; t++) begin
      set_in(t, 600, 20, 1, 1'b0, 1'b0, 0, 0, 0);
      launch();
      wait_done();
      first = model(t, 600, 20, 1, 1'b0, 1'b0, 0, 0, 0);
      check("R10 first result", got(), first);
      set_in(4 + t, 120, 33, 3, 1'b0, 1'b0, 0, 0, 0);
      launch();
      check("R10 busy after overlapped start", {got(), busy, valid}, {first, 2'b10});
      wait_done();
      check("R10 second result", got(), model(4 + t, 120, 33, 3, 1'b0, 1'b0, 0, 0, 0));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule